// File: doc/BRIEF.md
# Register Producer Tag Table

This block tracks, for each architectural register of an out-of-order core, whether the register file already holds the register's current value. When the value is still being computed, the block records the reorder-buffer tag of the in-flight instruction that will produce it. The issue stage writes an entry when an instruction that targets a register is issued. The retire stage writes an entry when a result is committed. A clear pulse, used for a pipeline flush, makes every register readable from the register file again.

The block also resolves one source operand per cycle, using combinational logic. A source is described by a register class and a register address. The operand is taken from the first of these that applies:

- a hard-wired zero, for integer register 0 or when no source is selected;
- the register file, when the entry is valid;
- the result bus, when its tag matches the stored tag;
- the reorder-buffer entry named by the stored tag.

The reorder buffer is read through a combinational port whose index the block drives. Register-file storage lives outside the block.

Top module: `regtag_scoreboard`

## Requirements
- R1: After reset, every entry is valid with tag 0. A lookup of any register other than integer register 0 returns valid, tag 0 and the register-file data.
- R2: An issue write (`iss_en`) makes the addressed entry invalid and stores `iss_tag`, visible from the cycle after the clock edge.
- R3: A writeback (`wb_en`) makes the addressed entry valid only when `wb_tag` equals the entry's stored tag. Otherwise the entry keeps its validity and tag.
- R4: When an issue write and a writeback address the same entry in one cycle, the issue write takes effect and the writeback is discarded.
- R5: An issue write and a writeback to different entries in the same cycle both take effect.
- R6: A lookup with class code 1 (integer) and address 0 returns valid, tag 0 and data 0, whatever the table, bus and reorder buffer hold.
- R7: For a selected source other than integer register 0 whose entry is valid, the lookup returns valid, the stored tag and `rf_data`.
- R8: For an invalid entry, when the result bus is valid and its tag equals the stored tag, the lookup returns valid and the stored tag. The data is `bus_hi` for class code 3 (high half) and `bus_lo` for class code 2 (low half) or code 1 (integer).
- R9: For an invalid entry with no matching bus result, the lookup returns `rob_valid` and the stored tag. The data is `rob_hi` for class code 3 and `rob_lo` otherwise.
- R10: A lookup with class code 0 (no source) returns valid, tag 0 and data 0.
- R11: Clear (`clr`) makes every entry valid with tag 0 on the next edge. It overrides an issue write or a writeback in the same cycle.
- R12: `rob_idx` always equals the stored tag of the entry at `src_addr`, for every source class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Flush: all entries valid, tag 0 |
| iss_en | input | 1 | Issue write enable |
| iss_addr | input | ADDR_W | Issue destination register |
| iss_tag | input | TAG_W | Tag of the issuing instruction |
| wb_en | input | 1 | Writeback enable |
| wb_addr | input | ADDR_W | Writeback destination register |
| wb_tag | input | TAG_W | Tag of the retiring instruction |
| src_kind | input | 2 | Source class: 0 none, 1 integer, 2 low half, 3 high half |
| src_addr | input | ADDR_W | Source register address |
| rf_data | input | DATA_W | Register-file data for the source |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Result bus tag |
| bus_lo | input | DATA_W | Result bus low word |
| bus_hi | input | DATA_W | Result bus high word |
| rob_idx | output | TAG_W | Reorder-buffer read index |
| rob_valid | input | 1 | Indexed reorder-buffer entry holds its result |
| rob_lo | input | DATA_W | Indexed reorder-buffer low word |
| rob_hi | input | DATA_W | Indexed reorder-buffer high word |
| op_valid | output | 1 | Operand value is available |
| op_tag | output | TAG_W | Producer tag of the operand |
| op_data | output | DATA_W | Operand value |

## Verification
The hardest situation to reach is a writeback that collides with an issue write, either to the same entry or to another entry. This needs two pipeline ports active in one cycle with carefully chosen stored tags.

The stimulus first gives an entry a known tag. It then drives both ports in one cycle, once with equal addresses and once with different addresses, and reads each entry back through the lookup path.

The bench's reorder buffer is a table indexed by the block's `rob_idx`, with alternating valid bits. A wrong index therefore shows up as wrong data or a wrong validity. Result-bus tags are chosen both to match and to miss the stored tag.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
   typedef enum logic [1:0] {
      SK_NONE = 2'd0,
      SK_INT  = 2'd1,
      SK_LO   = 2'd2,
      SK_HI   = 2'd3
   } src_kind_e;
endpackage

// File: rtl/regtag_dec.sv
module regtag_dec #(
   parameter int ADDR_W = 5,
   parameter int NREGS  = 32
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NREGS-1:0]  hit
);
   for (genvar i = 0; i < NREGS; i++) begin : g_hit
      assign hit[i] = en && (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/regtag_entry.sv
module regtag_entry #(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             iss_hit,
   input  logic [TAG_W-1:0] iss_tag,
   input  logic             wb_hit,
   input  logic [TAG_W-1:0] wb_tag,
   output logic             valid,
   output logic [TAG_W-1:0] tag
);
   logic tag_match;
   assign tag_match = (wb_tag == tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b1;
         tag   <= '0;
      end else if (clr) begin
         valid <= 1'b1;
         tag   <= '0;
      end else if (iss_hit) begin
         valid <= 1'b0;
         tag   <= iss_tag;
      end else if (wb_hit && tag_match) begin
         valid <= 1'b1;
      end
   end
endmodule

// File: rtl/regtag_opsel.sv
module regtag_opsel
   import regtag_pkg::*;
#(
   parameter int TAG_W     = 4,
   parameter int DATA_W    = 32,
   parameter bit HARD_ZERO = 1'b1
) (
   input  src_kind_e         kind,
   input  logic              addr_is_zero,
   input  logic              ent_valid,
   input  logic [TAG_W-1:0]  ent_tag,
   input  logic [DATA_W-1:0] rf_data,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_lo,
   input  logic [DATA_W-1:0] bus_hi,
   input  logic              rob_valid,
   input  logic [DATA_W-1:0] rob_lo,
   input  logic [DATA_W-1:0] rob_hi,
   output logic              op_valid,
   output logic [TAG_W-1:0]  op_tag,
   output logic [DATA_W-1:0] op_data
);
   logic zero_src;
   logic high_half;
   logic bus_hit;

   if (HARD_ZERO) begin : g_zero
      assign zero_src = (kind == SK_NONE) || ((kind == SK_INT) && addr_is_zero);
   end else begin : g_nozero
      assign zero_src = (kind == SK_NONE);
   end

   assign high_half = (kind == SK_HI);
   assign bus_hit   = bus_valid && (bus_tag == ent_tag);

   always_comb begin
      if (zero_src) begin
         op_valid = 1'b1;
         op_tag   = '0;
         op_data  = '0;
      end else if (ent_valid) begin
         op_valid = 1'b1;
         op_tag   = ent_tag;
         op_data  = rf_data;
      end else if (bus_hit) begin
         op_valid = 1'b1;
         op_tag   = ent_tag;
         op_data  = high_half ? bus_hi : bus_lo;
      end else begin
         op_valid = rob_valid;
         op_tag   = ent_tag;
         op_data  = high_half ? rob_hi : rob_lo;
      end
   end
endmodule

// File: rtl/regtag_scoreboard.sv
module regtag_scoreboard
   import regtag_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int TAG_W     = 4,
   parameter int DATA_W    = 32,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              iss_en,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              wb_en,
   input  logic [ADDR_W-1:0] wb_addr,
   input  logic [TAG_W-1:0]  wb_tag,
   input  logic [1:0]        src_kind,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [DATA_W-1:0] rf_data,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_lo,
   input  logic [DATA_W-1:0] bus_hi,
   output logic [TAG_W-1:0]  rob_idx,
   input  logic              rob_valid,
   input  logic [DATA_W-1:0] rob_lo,
   input  logic [DATA_W-1:0] rob_hi,
   output logic              op_valid,
   output logic [TAG_W-1:0]  op_tag,
   output logic [DATA_W-1:0] op_data
);
   localparam int NREGS = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("regtag_scoreboard: ADDR_W out of range");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("regtag_scoreboard: TAG_W must be positive");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("regtag_scoreboard: DATA_W must be positive");
   end

   logic [NREGS-1:0]            iss_hit;
   logic [NREGS-1:0]            wb_hit;
   logic [NREGS-1:0]            ent_valid;
   logic [NREGS-1:0][TAG_W-1:0] ent_tag;
   logic                        sel_valid;
   logic [TAG_W-1:0]            sel_tag;
   src_kind_e                   kind;

   assign kind = src_kind_e'(src_kind);

   regtag_dec #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_iss_dec (
      .en(iss_en), .addr(iss_addr), .hit(iss_hit)
   );
   regtag_dec #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_wb_dec (
      .en(wb_en), .addr(wb_addr), .hit(wb_hit)
   );

   for (genvar i = 0; i < NREGS; i++) begin : g_ent
      regtag_entry #(.TAG_W(TAG_W)) u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .iss_hit (iss_hit[i]),
         .iss_tag (iss_tag),
         .wb_hit  (wb_hit[i]),
         .wb_tag  (wb_tag),
         .valid   (ent_valid[i]),
         .tag     (ent_tag[i])
      );
   end

   assign sel_valid = ent_valid[src_addr];
   assign sel_tag   = ent_tag[src_addr];
   assign rob_idx   = sel_tag;

   regtag_opsel #(.TAG_W(TAG_W), .DATA_W(DATA_W), .HARD_ZERO(HARD_ZERO)) u_opsel (
      .kind         (kind),
      .addr_is_zero (src_addr == '0),
      .ent_valid    (sel_valid),
      .ent_tag      (sel_tag),
      .rf_data      (rf_data),
      .bus_valid    (bus_valid),
      .bus_tag      (bus_tag),
      .bus_lo       (bus_lo),
      .bus_hi       (bus_hi),
      .rob_valid    (rob_valid),
      .rob_lo       (rob_lo),
      .rob_hi       (rob_hi),
      .op_valid     (op_valid),
      .op_tag       (op_tag),
      .op_data      (op_data)
   );
endmodule

// File: rtl/regtag_chk.sv
module regtag_chk
   import regtag_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 32,
   parameter int NREGS  = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        clr,
   input logic                        iss_en,
   input logic [ADDR_W-1:0]           iss_addr,
   input logic [TAG_W-1:0]            iss_tag,
   input logic                        wb_en,
   input logic [ADDR_W-1:0]           wb_addr,
   input logic [TAG_W-1:0]            wb_tag,
   input logic [1:0]                  src_kind,
   input logic [ADDR_W-1:0]           src_addr,
   input logic [DATA_W-1:0]           rf_data,
   input logic [TAG_W-1:0]            rob_idx,
   input logic                        op_valid,
   input logic [TAG_W-1:0]            op_tag,
   input logic [DATA_W-1:0]           op_data,
   input logic [NREGS-1:0]            ent_valid,
   input logic [NREGS-1:0][TAG_W-1:0] ent_tag
);
   // R2 R4
   issue_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_en && !clr) |=> (!ent_valid[$past(iss_addr)] && ent_tag[$past(iss_addr)] == $past(iss_tag)));

   // R3
   wb_mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !clr && !(iss_en && iss_addr == wb_addr) && ent_tag[wb_addr] != wb_tag)
      |=> (ent_valid[$past(wb_addr)] == $past(ent_valid[wb_addr]) &&
           ent_tag[$past(wb_addr)] == $past(ent_tag[wb_addr])));

   // R11
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (&ent_valid));

   // R6
   int_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_kind == 2'd1 && src_addr == '0) |-> (op_valid && op_tag == '0 && op_data == '0));

   // R10
   no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_kind == 2'd0) |-> (op_valid && op_tag == '0 && op_data == '0));

   // R7
   valid_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_kind != 2'd0 && !(src_kind == 2'd1 && src_addr == '0) && ent_valid[src_addr])
      |-> (op_valid && op_data == rf_data && op_tag == ent_tag[src_addr]));

   // R12
   rob_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rob_idx == ent_tag[src_addr]);
endmodule

bind regtag_scoreboard regtag_chk #(
   .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .NREGS(1 << ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr),
   .iss_en(iss_en), .iss_addr(iss_addr), .iss_tag(iss_tag),
   .wb_en(wb_en), .wb_addr(wb_addr), .wb_tag(wb_tag),
   .src_kind(src_kind), .src_addr(src_addr), .rf_data(rf_data),
   .rob_idx(rob_idx), .op_valid(op_valid), .op_tag(op_tag), .op_data(op_data),
   .ent_valid(ent_valid), .ent_tag(ent_tag)
);

// File: tb/sim_regtag_scoreboard.sv
module sim_regtag_scoreboard;
   import regtag_pkg::*;
   localparam int AW = 5, TW = 4, DW = 32, NR = 32, NROB = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, clr, iss_en, wb_en, bus_valid;
   logic [AW-1:0] iss_addr, wb_addr, src_addr;
   logic [TW-1:0] iss_tag, wb_tag, bus_tag, rob_idx, op_tag;
   logic [1:0]    src_kind;
   logic [DW-1:0] rf_data, bus_lo, bus_hi, rob_lo, rob_hi, op_data;
   logic          rob_valid, op_valid;

   logic          robv [NROB];
   logic [DW-1:0] robl [NROB];
   logic [DW-1:0] robh [NROB];
   assign rob_valid = robv[rob_idx];
   assign rob_lo    = robl[rob_idx];
   assign rob_hi    = robh[rob_idx];

   regtag_scoreboard #(.ADDR_W(AW), .TAG_W(TW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .iss_en(iss_en), .iss_addr(iss_addr), .iss_tag(iss_tag),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_tag(wb_tag),
      .src_kind(src_kind), .src_addr(src_addr), .rf_data(rf_data),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_lo(bus_lo), .bus_hi(bus_hi),
      .rob_idx(rob_idx), .rob_valid(rob_valid), .rob_lo(rob_lo), .rob_hi(rob_hi),
      .op_valid(op_valid), .op_tag(op_tag), .op_data(op_data)
   );

   typedef struct {
      logic          v;
      logic [TW-1:0] t;
      logic [DW-1:0] d;
      logic [TW-1:0] ri;
      string         req;
   } item_t;

   item_t         q[$];
   int            checks = 0;
   int            errs   = 0;
   bit            done   = 0;
   logic          mv [NR];
   logic [TW-1:0] mt [NR];

   task automatic cyc(bit cl, bit ie, int ia, int it, bit we, int wa, int wt);
      @(negedge clk);
      clr = cl; iss_en = ie; iss_addr = AW'(ia); iss_tag = TW'(it);
      wb_en = we; wb_addr = AW'(wa); wb_tag = TW'(wt);
      @(posedge clk);
      if (cl) begin
         for (int i = 0; i < NR; i++) begin mv[i] = 1'b1; mt[i] = '0; end
      end else begin
         if (we && !(ie && ia == wa) && mt[wa] == TW'(wt)) mv[wa] = 1'b1;
         if (ie) begin mv[ia] = 1'b0; mt[ia] = TW'(it); end
      end
   endtask

   task automatic look(int k, int a, logic [DW-1:0] rf, bit bv, int bt,
                       logic [DW-1:0] bl, logic [DW-1:0] bh, string req);
      item_t e;
      @(negedge clk);
      clr = 0; iss_en = 0; wb_en = 0;
      src_kind = 2'(k); src_addr = AW'(a); rf_data = rf;
      bus_valid = bv; bus_tag = TW'(bt); bus_lo = bl; bus_hi = bh;
      e.req = req;
      e.ri  = mt[a];
      if (k == 0 || (k == 1 && a == 0)) begin
         e.v = 1; e.t = '0; e.d = '0;
      end else if (mv[a]) begin
         e.v = 1; e.t = mt[a]; e.d = rf;
      end else if (bv && TW'(bt) == mt[a]) begin
         e.v = 1; e.t = mt[a]; e.d = (k == 3) ? bh : bl;
      end else begin
         e.v = robv[mt[a]]; e.t = mt[a]; e.d = (k == 3) ? robh[mt[a]] : robl[mt[a]];
      end
      q.push_back(e);
   endtask

   // monitor: compares queued expectations after inputs settle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            checks++;
            if (op_valid !== e.v || op_tag !== e.t || op_data !== e.d || rob_idx !== e.ri) begin
               errs++;
               $display("FAIL %s: got v=%0b t=%0d d=%h idx=%0d, expected v=%0b t=%0d d=%h idx=%0d",
                        e.req, op_valid, op_tag, op_data, rob_idx, e.v, e.t, e.d, e.ri);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 0; clr = 0; iss_en = 0; wb_en = 0;
      iss_addr = '0; wb_addr = '0; iss_tag = '0; wb_tag = '0;
      src_kind = '0; src_addr = '0; rf_data = '0;
      bus_valid = 0; bus_tag = '0; bus_lo = '0; bus_hi = '0;
      for (int i = 0; i < NROB; i++) begin
         robv[i] = (i % 2 == 1);
         robl[i] = 32'hA000_0000 + i;
         robh[i] = 32'hB000_0000 + i;
      end
      for (int i = 0; i < NR; i++) begin mv[i] = 1'b1; mt[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 reset state across the table
      for (int a = 1; a < NR; a += 5) look(1, a, 32'h1000 + a, 0, 0, 0, 0, "R1");
      // R2 issue, then R9 reorder-buffer fallback (valid and invalid slots)
      cyc(0, 1, 5, 3, 0, 0, 0);
      look(1, 5, 32'h55, 0, 0, 0, 0, "R2");
      look(3, 5, 32'h55, 0, 0, 0, 0, "R9");
      cyc(0, 1, 6, 4, 0, 0, 0);
      look(2, 6, 32'h66, 0, 0, 0, 0, "R9");
      // R8 bus forwarding, low and high words
      look(2, 6, 32'h66, 1, 4, 32'hC0C0_0001, 32'hD0D0_0002, "R8");
      look(3, 6, 32'h66, 1, 4, 32'hC0C0_0001, 32'hD0D0_0002, "R8");
      look(1, 6, 32'h66, 1, 7, 32'hC0C0_0001, 32'hD0D0_0002, "R9");
      // R3 writeback with wrong tag is ignored, matching tag validates
      cyc(0, 0, 0, 0, 1, 6, 9);
      look(2, 6, 32'h66, 0, 0, 0, 0, "R3");
      cyc(0, 0, 0, 0, 1, 6, 4);
      look(2, 6, 32'h66, 0, 0, 0, 0, "R3");
      // R7 valid entry keeps its stored tag
      look(3, 6, 32'h6767, 1, 4, 32'h1, 32'h2, "R7");
      // R4 issue beats writeback on the same entry
      cyc(0, 1, 7, 2, 1, 7, 0);
      look(1, 7, 32'h77, 0, 0, 0, 0, "R4");
      // R5 issue and writeback to different entries
      cyc(0, 1, 8, 5, 1, 5, 3);
      look(1, 5, 32'h5555, 0, 0, 0, 0, "R5");
      look(1, 8, 32'h8888, 0, 0, 0, 0, "R5");
      // R6 integer register zero is hard-wired even when written
      cyc(0, 1, 0, 6, 0, 0, 0);
      look(1, 0, 32'hFFFF_FFFF, 1, 6, 32'h3, 32'h4, "R6");
      look(2, 0, 32'hFFFF_FFFF, 1, 6, 32'h3, 32'h4, "R8");
      // R10 no source selected
      look(0, 8, 32'h1234, 1, 5, 32'h9, 32'h9, "R10");
      // R12 index follows the stored tag
      cyc(0, 1, 9, 11, 0, 0, 0);
      look(1, 9, 32'h99, 1, 10, 32'h9, 32'h9, "R12");
      look(3, 9, 32'h99, 0, 0, 0, 0, "R12");
      // R11 clear overrides a simultaneous issue
      cyc(1, 1, 9, 1, 1, 8, 5);
      look(1, 9, 32'h909, 0, 0, 0, 0, "R11");
      look(2, 7, 32'h707, 0, 0, 0, 0, "R11");
      look(3, 0, 32'h000A, 0, 0, 0, 0, "R11");
      look(1, 8, 32'h808, 0, 0, 0, 0, "R11");

      @(negedge clk);
      #2;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule